// File: doc/BRIEF.md
# Prescaled Bidirectional Event Timer

This block is a timer counter whose advance is set by a programmable prescaler. The prescaler acts as a fractional stage below the counter. It runs from 0 up to a limit value, and the counter steps once each time the prescaler wraps. A zero prescaler limit bypasses the stage. The prescaler can step on every bus clock. In the edge clock mode it steps only in bus-clock cycles where a chosen edge (rising or falling) of an external clock input has just been seen.

Several event channels are evaluated against the counter in every cycle. Each channel can look at an I/O condition (level or edge on a selected input), a match of the counter against a selected compare value, or both, combined by OR or AND. A fired event is tagged with the part that caused it: I/O, match or both. Events enabled in a limit mask act as limit events. In up-only mode a limit event returns the counter to zero. In bidirectional mode it clears the direction flag instead.

The halt and stop controls gate the prescaler, the counter and the events. Software can load the counter or clear it, and either action also zeroes the prescaler.

Top module: `prescaled_event_timer`

## Requirements
- R1: After reset the counter is 0, the direction flag (`down`) is 0 and the prescaler is 0.
- R2: The prescaler is enabled in a cycle when halt and stop are both 0 and either `clk_mode` is not 2'b01 or the selected edge of `ext_clk` is seen. The edge is found against the sample from the previous bus clock: `edge_rise`=1 selects 0→1 and `edge_rise`=0 selects 1→0.
- R3: The counter is enabled in a cycle when the prescaler is enabled and either `pre_lim` is 0 or the prescaler equals `pre_lim`. When enabled, the prescaler goes back to 0 in that cycle, and otherwise it increments.
- R4: A software write (`sw_wr`) loads `sw_wdata` into the counter and has priority over everything else. A clear command (`clr_cmd`) sets the counter to 0 and has priority over limit and count updates. Both actions zero the prescaler and leave `down` unchanged.
- R5: With `bidir`=0, an enabled count increments the counter, wrapping from all ones to 0. A limit event sets the counter to 0 and clears `down`. The prescaler is zeroed only when a limit event carrying an I/O tag fires. A limit event that is only match-derived leaves the prescaler on its normal step.
- R6: With `bidir`=1, an enabled count moves up while `down`=0. At the all-ones value it sets `down` and loads all-ones minus one. While `down`=1 it moves down, and at 0 it clears `down` and loads 1. A limit event clears `down` and decrements the counter (modulo) if the counter is enabled in that cycle. It leaves the prescaler alone.
- R7: The I/O condition code of each event is 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Edges are taken against the previous bus-clock sample of the input, which reset sets to 0.
- R8: The combine code of each event is 0 = I/O OR match, 1 = match only, 2 = I/O only, 3 = I/O AND match. The I/O part qualifies whenever halt is 0. The match part, and the whole of an AND event, qualify only when halt is 0, stop is 0 and the counter is enabled in that cycle.
- R9: `ev_io_tag` marks an event fired by its I/O part and `ev_match_tag` marks one fired by its match part. An AND event sets both, and `ev_fire` is the OR of the two tags.
- R10: While halt is 1 no event fires and the counter and prescaler hold. While stop is 1 the counter and prescaler hold, but I/O-qualified events still fire.
- R11: The match part of an event is true when the counter equals the compare value chosen by that event's match select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_mode | input | 2 | 2'b01 = count on external edge, other = every bus clock |
| edge_rise | input | 1 | 1 = rising, 0 = falling edge of ext_clk |
| ext_clk | input | 1 | External clock input, synchronous to clk |
| pre_lim | input | PRE_W | Prescaler limit, 0 = bypass |
| bidir | input | 1 | 1 = up/down counting |
| halt | input | 1 | Freeze counting and all events |
| stop | input | 1 | Freeze counting and match events |
| io_in | input | N_IO | I/O event inputs |
| match_val | input | N_MATCH*CNT_W | Packed compare values |
| ev_io_sel | input | N_EV*IOS_W | Per-event I/O input select |
| ev_io_cond | input | N_EV*2 | Per-event I/O condition code |
| ev_m_sel | input | N_EV*MS_W | Per-event compare value select |
| ev_comb | input | N_EV*2 | Per-event combine code |
| limit_mask | input | N_EV | Events acting as limit |
| sw_wr | input | 1 | Software counter write |
| sw_wdata | input | CNT_W | Software write value |
| clr_cmd | input | 1 | Clear counter command |
| count | output | CNT_W | Counter value |
| down | output | 1 | Direction flag |
| ev_fire | output | N_EV | Qualified event strobes |
| ev_io_tag | output | N_EV | Event fired by I/O part |
| ev_match_tag | output | N_EV | Event fired by match part |

## Verification
The counter path is first run with the prescaler at 0 and at non-zero limits on the free-running clock. It is then run in edge mode with a random external clock under both edge polarities, which separates the enable qualification from the prescaler compare. Random I/O waveforms against compare values near the live counter drive all four condition codes and all four combine codes, with halt and stop toggled, so that an I/O-tagged event can be told apart from a match-tagged one. Up-only limit runs expose whether the prescaler is cleared by the right kind of limit. Bidirectional runs preloaded near the top value exercise both turn-around points and the limit decrement, and random software writes and clears overlap all of these.

// File: rtl/pet_pkg.sv
package pet_pkg;
  localparam logic [1:0] MODE_EXT_EDGE = 2'b01;

  localparam logic [1:0] COND_LOW  = 2'd0;
  localparam logic [1:0] COND_HIGH = 2'd1;
  localparam logic [1:0] COND_RISE = 2'd2;
  localparam logic [1:0] COND_FALL = 2'd3;

  localparam logic [1:0] COMB_OR    = 2'd0;
  localparam logic [1:0] COMB_MATCH = 2'd1;
  localparam logic [1:0] COMB_IO    = 2'd2;
  localparam logic [1:0] COMB_AND   = 2'd3;

  function automatic logic io_cond_hit(input logic [1:0] cond, input logic cur, input logic prev);
    case (cond)
      COND_LOW:  return ~cur;
      COND_HIGH: return cur;
      COND_RISE: return cur & ~prev;
      default:   return ~cur & prev;
    endcase
  endfunction

  function automatic logic edge_seen(input logic rise, input logic cur, input logic prev);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/pet_prescaler.sv
module pet_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_mode,
  input  logic             edge_rise,
  input  logic             ext_clk,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic             pre_clr,
  output logic             pre_en,
  output logic             cnt_en,
  output logic [PRE_W-1:0] pre_q
);
  import pet_pkg::*;

  logic ext_prev;
  logic edge_hit;
  logic at_lim;

  assign edge_hit = edge_seen(edge_rise, ext_clk, ext_prev);
  assign pre_en   = run & ((clk_mode != MODE_EXT_EDGE) | edge_hit);
  assign at_lim   = (pre_lim == '0) | (pre_q == pre_lim);
  assign cnt_en   = pre_en & at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      pre_q    <= '0;
    end else begin
      ext_prev <= ext_clk;
      if (pre_clr)     pre_q <= '0;
      else if (pre_en) pre_q <= at_lim ? '0 : pre_q + 1'b1;
    end
  end

  // R4
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_clr |=> (pre_q == '0));

  // R10
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pre_clr) |=> $stable(pre_q));
endmodule

// File: rtl/pet_event_qual.sv
module pet_event_qual #(
  parameter int N_EV    = 4,
  parameter int N_IO    = 4,
  parameter int N_MATCH = 4,
  parameter int CNT_W   = 16,
  localparam int IOS_W  = (N_IO > 1) ? $clog2(N_IO) : 1,
  localparam int MS_W   = (N_MATCH > 1) ? $clog2(N_MATCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     halt,
  input  logic                     stop,
  input  logic                     cnt_en,
  input  logic [CNT_W-1:0]         count,
  input  logic [N_IO-1:0]          io_in,
  input  logic [N_MATCH*CNT_W-1:0] match_val,
  input  logic [N_EV*IOS_W-1:0]    ev_io_sel,
  input  logic [N_EV*2-1:0]        ev_io_cond,
  input  logic [N_EV*MS_W-1:0]     ev_m_sel,
  input  logic [N_EV*2-1:0]        ev_comb,
  output logic [N_EV-1:0]          ev_fire,
  output logic [N_EV-1:0]          ev_io_tag,
  output logic [N_EV-1:0]          ev_match_tag
);
  import pet_pkg::*;

  logic [N_IO-1:0]  io_prev;
  logic [CNT_W-1:0] cmp [N_MATCH];
  logic             io_ok;
  logic             m_ok;

  assign io_ok = ~halt;
  assign m_ok  = ~halt & ~stop & cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_prev <= '0;
    else        io_prev <= io_in;
  end

  for (genvar m = 0; m < N_MATCH; m++) begin : g_cmp
    assign cmp[m] = match_val[m*CNT_W +: CNT_W];
  end

  for (genvar e = 0; e < N_EV; e++) begin : g_ev
    logic [IOS_W-1:0] isel;
    logic [MS_W-1:0]  msel;
    logic [1:0]       comb;
    logic             io_hit;
    logic             m_hit;

    assign isel   = ev_io_sel[e*IOS_W +: IOS_W];
    assign msel   = ev_m_sel[e*MS_W +: MS_W];
    assign comb   = ev_comb[e*2 +: 2];
    assign io_hit = io_cond_hit(ev_io_cond[e*2 +: 2], io_in[isel], io_prev[isel]);
    assign m_hit  = (count == cmp[msel]);

    always_comb begin
      ev_io_tag[e]    = 1'b0;
      ev_match_tag[e] = 1'b0;
      case (comb)
        COMB_OR: begin
          ev_io_tag[e]    = io_hit & io_ok;
          ev_match_tag[e] = m_hit & m_ok;
        end
        COMB_MATCH: ev_match_tag[e] = m_hit & m_ok;
        COMB_IO:    ev_io_tag[e]    = io_hit & io_ok;
        default: begin
          ev_io_tag[e]    = io_hit & m_hit & m_ok;
          ev_match_tag[e] = io_hit & m_hit & m_ok;
        end
      endcase
    end
  end

  assign ev_fire = ev_io_tag | ev_match_tag;

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (ev_fire == '0));

  // R8
  match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_match_tag != '0) |-> (cnt_en && !stop && !halt));
endmodule

// File: rtl/pet_counter.sv
module pet_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bidir,
  input  logic             cnt_en,
  input  logic             limit_any,
  input  logic             sw_wr,
  input  logic [CNT_W-1:0] sw_wdata,
  input  logic             clr_cmd,
  output logic [CNT_W-1:0] count,
  output logic             down
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return v + CNT_ONE;
  endfunction

  function automatic logic [CNT_W-1:0] step_dn(input logic [CNT_W-1:0] v);
    return v - CNT_ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      down  <= 1'b0;
    end else if (sw_wr) begin
      count <= sw_wdata;
    end else if (clr_cmd) begin
      count <= '0;
    end else if (!bidir) begin
      down <= 1'b0;
      if (limit_any)   count <= '0;
      else if (cnt_en) count <= step_up(count);
    end else if (limit_any) begin
      down <= 1'b0;
      if (cnt_en) count <= step_dn(count);
    end else if (cnt_en) begin
      if (!down) begin
        if (count == CNT_MAX) begin
          down  <= 1'b1;
          count <= step_dn(CNT_MAX);
        end else begin
          count <= step_up(count);
        end
      end else begin
        if (count == '0) begin
          down  <= 1'b0;
          count <= CNT_ONE;
        end else begin
          count <= step_dn(count);
        end
      end
    end
  end

  // R4
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (count == $past(sw_wdata)));

  // R5
  updir_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bidir && !sw_wr && !clr_cmd) |=> !down);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !limit_any && !sw_wr && !clr_cmd) |=> $stable(count));
endmodule

// File: rtl/prescaled_event_timer.sv
module prescaled_event_timer #(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int N_EV    = 4,
  parameter int N_IO    = 4,
  parameter int N_MATCH = 4,
  localparam int IOS_W  = (N_IO > 1) ? $clog2(N_IO) : 1,
  localparam int MS_W   = (N_MATCH > 1) ? $clog2(N_MATCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               clk_mode,
  input  logic                     edge_rise,
  input  logic                     ext_clk,
  input  logic [PRE_W-1:0]         pre_lim,
  input  logic                     bidir,
  input  logic                     halt,
  input  logic                     stop,
  input  logic [N_IO-1:0]          io_in,
  input  logic [N_MATCH*CNT_W-1:0] match_val,
  input  logic [N_EV*IOS_W-1:0]    ev_io_sel,
  input  logic [N_EV*2-1:0]        ev_io_cond,
  input  logic [N_EV*MS_W-1:0]     ev_m_sel,
  input  logic [N_EV*2-1:0]        ev_comb,
  input  logic [N_EV-1:0]          limit_mask,
  input  logic                     sw_wr,
  input  logic [CNT_W-1:0]         sw_wdata,
  input  logic                     clr_cmd,
  output logic [CNT_W-1:0]         count,
  output logic                     down,
  output logic [N_EV-1:0]          ev_fire,
  output logic [N_EV-1:0]          ev_io_tag,
  output logic [N_EV-1:0]          ev_match_tag
);
  logic             run;
  logic             pre_en;
  logic             cnt_en;
  logic             pre_clr;
  logic [PRE_W-1:0] pre_q;
  logic             limit_any;
  logic             limit_io;

  assign run       = ~halt & ~stop;
  assign limit_any = |(ev_fire & limit_mask);
  assign limit_io  = |(ev_io_tag & limit_mask);
  assign pre_clr   = sw_wr | clr_cmd | (~bidir & limit_io);

  pet_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .edge_rise(edge_rise),
    .ext_clk(ext_clk), .run(run), .pre_lim(pre_lim), .pre_clr(pre_clr),
    .pre_en(pre_en), .cnt_en(cnt_en), .pre_q(pre_q)
  );

  pet_event_qual #(.N_EV(N_EV), .N_IO(N_IO), .N_MATCH(N_MATCH), .CNT_W(CNT_W)) u_evq (
    .clk(clk), .rst_n(rst_n), .halt(halt), .stop(stop), .cnt_en(cnt_en),
    .count(count), .io_in(io_in), .match_val(match_val), .ev_io_sel(ev_io_sel),
    .ev_io_cond(ev_io_cond), .ev_m_sel(ev_m_sel), .ev_comb(ev_comb),
    .ev_fire(ev_fire), .ev_io_tag(ev_io_tag), .ev_match_tag(ev_match_tag)
  );

  pet_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bidir(bidir), .cnt_en(cnt_en),
    .limit_any(limit_any), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .clr_cmd(clr_cmd),
    .count(count), .down(down)
  );

  // R2
  edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && clk_mode == 2'b01) |-> (ext_clk != $past(ext_clk)));

  // R3
  count_needs_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> (pre_en && (pre_lim == '0 || pre_q == pre_lim)));
endmodule

// File: tb/tb_prescaled_event_timer.sv
module tb_prescaled_event_timer;
  localparam int CW = 16, PW = 8, NE = 4, NI = 4, NM = 4;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]     clk_mode = 2'd0;
  logic           edge_rise = 1'b1, ext_clk = 1'b0, bidir = 1'b0, halt = 1'b0, stop = 1'b0;
  logic [PW-1:0]  pre_lim = '0;
  logic [NI-1:0]  io_in = '0;
  logic [NE-1:0]  limit_mask = '0;
  logic           sw_wr = 1'b0, clr_cmd = 1'b0;
  logic [CW-1:0]  sw_wdata = '0;
  logic [1:0]     b_isel [NE], b_cond [NE], b_msel [NE], b_comb [NE];
  logic [CW-1:0]  b_mv [NM];
  logic [NM*CW-1:0] match_val;
  logic [NE*2-1:0]  ev_io_sel, ev_io_cond, ev_m_sel, ev_comb;
  logic [CW-1:0]  count;
  logic           down;
  logic [NE-1:0]  ev_fire, ev_io_tag, ev_match_tag;

  for (genvar i = 0; i < NE; i++) begin : g_pack
    assign ev_io_sel[i*2 +: 2]  = b_isel[i];
    assign ev_io_cond[i*2 +: 2] = b_cond[i];
    assign ev_m_sel[i*2 +: 2]   = b_msel[i];
    assign ev_comb[i*2 +: 2]    = b_comb[i];
  end
  for (genvar i = 0; i < NM; i++) begin : g_mv
    assign match_val[i*CW +: CW] = b_mv[i];
  end

  prescaled_event_timer dut (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .edge_rise(edge_rise), .ext_clk(ext_clk),
    .pre_lim(pre_lim), .bidir(bidir), .halt(halt), .stop(stop), .io_in(io_in),
    .match_val(match_val), .ev_io_sel(ev_io_sel), .ev_io_cond(ev_io_cond),
    .ev_m_sel(ev_m_sel), .ev_comb(ev_comb), .limit_mask(limit_mask), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .clr_cmd(clr_cmd), .count(count), .down(down),
    .ev_fire(ev_fire), .ev_io_tag(ev_io_tag), .ev_match_tag(ev_match_tag)
  );

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // reference state
  int m_cnt = 0, m_down = 0, m_pre = 0, m_ext_prev = 0;
  int m_io_prev [NI];
  int q_fire [$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // one clock: inputs already driven after a falling edge
  task automatic step();
    int ee, pe, ce, lany, lio, xf, xi, xm, n_cnt, n_down, n_pre;
    #1;
    ee = edge_rise ? (ext_clk && !m_ext_prev) : (!ext_clk && m_ext_prev);
    pe = !halt && !stop && (clk_mode != 2'b01 || ee);
    ce = pe && (pre_lim == 0 || m_pre == int'(pre_lim));
    xf = 0; xi = 0; xm = 0; lany = 0; lio = 0;
    for (int e = 0; e < NE; e++) begin
      int cur, prv, ih, mh, ti, tm;
      cur = io_in[b_isel[e]];
      prv = m_io_prev[b_isel[e]];
      case (b_cond[e])
        2'd0: ih = !cur;
        2'd1: ih = cur;
        2'd2: ih = cur && !prv;
        default: ih = !cur && prv;
      endcase
      mh = (m_cnt == int'(b_mv[b_msel[e]]));
      ti = 0; tm = 0;
      if (b_comb[e] == 2'd0) begin ti = ih && !halt; tm = mh && !halt && !stop && ce; end
      else if (b_comb[e] == 2'd1) tm = mh && !halt && !stop && ce;
      else if (b_comb[e] == 2'd2) ti = ih && !halt;
      else begin ti = ih && mh && !halt && !stop && ce; tm = ti; end
      if (ti) xi |= (1 << e);
      if (tm) xm |= (1 << e);
      if ((ti || tm) && limit_mask[e]) lany = 1;
      if (ti && limit_mask[e]) lio = 1;
    end
    xf = xi | xm;
    chk(cur_req, "R8 ev_fire", int'(ev_fire), xf);
    chk(cur_req, "R9 ev_io_tag", int'(ev_io_tag), xi);
    chk(cur_req, "R9 ev_match_tag", int'(ev_match_tag), xm);
    q_fire.push_back(xf);
    // next state
    n_cnt = m_cnt; n_down = m_down;
    if (sw_wr) n_cnt = int'(sw_wdata);
    else if (clr_cmd) n_cnt = 0;
    else if (!bidir) begin
      n_down = 0;
      if (lany) n_cnt = 0;
      else if (ce) n_cnt = (m_cnt + 1) % (CMAX + 1);
    end else if (lany) begin
      n_down = 0;
      if (ce) n_cnt = (m_cnt + CMAX) % (CMAX + 1);
    end else if (ce) begin
      if (!m_down) begin
        if (m_cnt == CMAX) begin n_down = 1; n_cnt = CMAX - 1; end
        else n_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin n_down = 0; n_cnt = 1; end
        else n_cnt = m_cnt - 1;
      end
    end
    if (sw_wr || clr_cmd || (!bidir && lio)) n_pre = 0;
    else if (pe) n_pre = ce ? 0 : (m_pre + 1) % 256;
    else n_pre = m_pre;
    @(posedge clk);
    m_cnt = n_cnt; m_down = n_down; m_pre = n_pre; m_ext_prev = ext_clk;
    for (int i = 0; i < NI; i++) m_io_prev[i] = io_in[i];
    @(negedge clk);
    chk(cur_req, "R3 R5 R6 count", int'(count), m_cnt);
    chk(cur_req, "R6 down", int'(down), m_down);
    if (q_fire.size() > 8) void'(q_fire.pop_front());
  endtask

  task automatic rand_events(int near);
    for (int e = 0; e < NE; e++) begin
      b_isel[e] = 2'($urandom_range(3));
      b_cond[e] = 2'($urandom_range(3));
      b_msel[e] = 2'($urandom_range(3));
      b_comb[e] = 2'($urandom_range(3));
    end
    for (int m = 0; m < NM; m++) b_mv[m] = 16'(near + $urandom_range(12));
  endtask

  task automatic quiet_events();
    for (int e = 0; e < NE; e++) begin
      b_isel[e] = 2'd0; b_cond[e] = 2'd0; b_msel[e] = 2'd0; b_comb[e] = 2'd1;
    end
    for (int m = 0; m < NM; m++) b_mv[m] = 16'hFFF0;
    limit_mask = '0;
  endtask

  initial begin
    for (int i = 0; i < NI; i++) m_io_prev[i] = 0;
    quiet_events();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, prescaler seen through the first count timing
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "down after reset", int'(down), 0);

    // R2 R3: free-running clock, several prescaler limits
    cur_req = "R3";
    for (int l = 0; l < 4; l++) begin
      pre_lim = 8'(l);
      repeat (25) step();
    end

    // R2: external edge mode, both polarities
    cur_req = "R2";
    clk_mode = 2'b01; pre_lim = 8'd1;
    for (int p = 0; p < 2; p++) begin
      edge_rise = p[0];
      for (int k = 0; k < 60; k++) begin
        ext_clk = 1'($urandom_range(1));
        step();
      end
    end
    clk_mode = 2'b10; pre_lim = 8'd0;

    // R7 R8 R9 R11: events on random I/O near the live count
    cur_req = "R7 R8 R9 R11";
    for (int k = 0; k < 300; k++) begin
      if (k % 20 == 0) rand_events(m_cnt);
      pre_lim = 8'($urandom_range(2));
      io_in = 4'($urandom);
      step();
    end

    // R5: up-only limit events with a running prescaler
    cur_req = "R5";
    for (int k = 0; k < 300; k++) begin
      if (k % 25 == 0) begin rand_events(0); limit_mask = 4'($urandom); pre_lim = 8'($urandom_range(1, 3)); end
      io_in = 4'($urandom);
      step();
    end

    // R6 R4: bidirectional turn-around near the top value
    cur_req = "R6";
    bidir = 1'b1; pre_lim = 8'd0; quiet_events();
    sw_wr = 1'b1; sw_wdata = 16'(CMAX - 5); step(); sw_wr = 1'b0;
    repeat (15) step();
    chk("R6", "down after top turn", int'(down), 1);
    sw_wr = 1'b1; sw_wdata = 16'd3; step(); sw_wr = 1'b0;
    repeat (8) step();
    chk("R6", "down after bottom turn", int'(down), 0);
    for (int k = 0; k < 200; k++) begin
      if (k % 30 == 0) begin
        rand_events(m_cnt); limit_mask = 4'($urandom); pre_lim = 8'($urandom_range(2));
        sw_wr = 1'b1; sw_wdata = 16'(CMAX - 8); step(); sw_wr = 1'b0;
      end
      io_in = 4'($urandom);
      step();
    end

    // R10: halt and stop
    cur_req = "R10";
    bidir = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (k % 20 == 0) begin rand_events(m_cnt); limit_mask = 4'($urandom); end
      halt = ($urandom_range(3) == 0);
      stop = ($urandom_range(2) == 0);
      io_in = 4'($urandom);
      step();
    end
    halt = 1'b0; stop = 1'b0;

    // R4: software writes and clears mixed with everything
    cur_req = "R4";
    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0) begin
        rand_events(m_cnt); limit_mask = 4'($urandom);
        bidir = 1'($urandom_range(1)); pre_lim = 8'($urandom_range(3));
        clk_mode = 2'($urandom_range(3));
      end
      sw_wr = ($urandom_range(7) == 0);
      sw_wdata = 16'($urandom_range(20));
      clr_cmd = ($urandom_range(5) == 0);
      ext_clk = 1'($urandom_range(1));
      halt = ($urandom_range(9) == 0);
      io_in = 4'($urandom);
      step();
    end
    sw_wr = 1'b0; clr_cmd = 1'b0;
    sw_wr = 1'b1; clr_cmd = 1'b1; sw_wdata = 16'd77; step();
    sw_wr = 1'b0; clr_cmd = 1'b0;
    chk("R4", "write wins over clear", int'(count) == 77 || m_cnt != 77 ? 1 : 0, 1);

    finish_run();
  end
endmodule